// File: doc/BRIEF.md
# I2C Register-Access Slave

This block lets an external I2C master read and write a bank of on-chip registers. The master addresses the block with a 7-bit chip address, set by a parameter, and then sends one 8-bit subaddress that picks a register. A parameter bitmap marks each subaddress as an 8-bit or a 16-bit register. A 16-bit register moves over the bus as two bytes, with the high byte first. Writes carry the data bytes straight after the subaddress. Reads write the subaddress, issue a repeated START, send the chip address again with the read bit set, and then clock the data out.

On the chip side, the block drives a parallel register port. It holds a write or read strobe, together with the address and write data, until the register file raises a ready signal. While a strobe is waiting, the block holds SCL low so the master pauses. The bus lines are sampled through a two-flop synchronizer. Both lines are driven open-drain: each one is modelled as an output enable that pulls the line low.

Top module: `i2c_regslave`

## Requirements
- R1: While reset is held and right after it, `sda_oe`, `scl_oe`, `reg_we` and `reg_re` are all low.
- R2: The slave drives ACK (SDA low on the ninth clock) after an address byte only when its upper 7 bits equal `CHIP_ADDR` (default 7'b1000111). The last bit of that byte selects the direction: 0 is write, 1 is read.
- R3: After an address byte that does not match, SDA is left high (NAK). The slave then acknowledges no byte and raises no strobe until the next START.
- R4: The first byte after a write-direction address is acknowledged and becomes `reg_addr` for the strobes that follow.
- R5: Subaddress s is a 16-bit register when `WIDE_MAP[s]` is 1 and an 8-bit register otherwise. By default, subaddresses 0x80 to 0xFF are 16-bit and 0x00 to 0x7F are 8-bit.
- R6: A data byte written to an 8-bit register commits at once, with `reg_wdata` = {8'h00, byte}.
- R7: A 16-bit write commits exactly once, with {high byte, low byte}, and only after the low byte arrives. A frame that stops after the high byte writes nothing.
- R8: Any data byte beyond the width of the register is NAKed and not written.
- R9: After the read sequence (START, address+W, subaddress, repeated START, address+R), the slave returns the register contents. An 8-bit register returns its low byte only.
- R10: A 16-bit read returns the high byte first and then, after the master ACKs, the low byte. Both bytes come from the single value captured on the one read strobe.
- R11: A strobe stays high, with `reg_addr` and `reg_wdata` stable, until `reg_ready` is sampled high. It then drops, so each commit or fetch is exactly one transfer. `reg_we` and `reg_re` are never high together.
- R12: `scl_oe` stays high while a strobe is pending and drops on the cycle after `reg_ready`. A transfer slowed in this way still completes correctly.
- R13: A STOP, or a START, at any point returns the slave to its idle or address state with SDA released. A byte cut short by a START commits nothing.
- R14: The slave changes `sda_oe` only after a falling SCL edge, so its SDA output never moves while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low (ACK or data 0) |
| reg_addr | output | SUB_W | Register subaddress |
| reg_wdata | output | 16 | Write data, high byte in [15:8] |
| reg_we | output | 1 | Write strobe, held until ready |
| reg_re | output | 1 | Read strobe, held until ready |
| reg_rdata | input | 16 | Read data, sampled with ready |
| reg_ready | input | 1 | Register port accepts the strobe |

## Verification
Some properties are checked on every cycle. The strobe handshake must hold address and data steady until ready, and the two strobes are mutually exclusive. SCL must be held low for as long as a strobe is pending and released right after ready. The slave's SDA output may move only after a falling SCL edge, and a STOP leaves both lines released. Other behaviour shows only in the bench's bus scenarios, because it depends on whole byte sequences:
- which bytes are ACKed;
- the merging of high and low bytes in 16-bit writes and their atomicity;
- the read-path snapshot;
- the 8-bit/16-bit boundary in the width map;
- recovery after a mismatched address or an interrupted byte.

// File: rtl/i2c_regslave_pkg.sv
// Package: shared constants and the transfer-phase type of the I2C register slave.
package i2c_regslave_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_SUB,
        PH_WDATA,
        PH_RDATA
    } phase_t;
endpackage

// File: rtl/i2c_regslave_sync.sv
// Bus sampler: passes SCL and SDA through STAGES flops and derives the edge
// and START/STOP events from the synchronized levels.
// Assumes STAGES >= 2 and that the lines idle high.
module i2c_regslave_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int CHAIN_W = 2 * STAGES;

    logic [CHAIN_W-1:0] chain;
    logic scl_s, scl_q, sda_q;

    // Shift both lines through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[CHAIN_W-3:0], scl_i, sda_i};
    end

    assign scl_s = chain[CHAIN_W-1];
    assign sda_s = chain[CHAIN_W-2];

    // Keep the previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  =  scl_s & ~scl_q;
    assign scl_fall  = ~scl_s &  scl_q;
    assign start_det =  scl_s &  scl_q &  sda_q & ~sda_s;
    assign stop_det  =  scl_s &  scl_q & ~sda_q &  sda_s;
endmodule

// File: rtl/i2c_regslave_wmap.sv
// Width lookup: reports whether a subaddress names a 16-bit register.
// Assumes WIDE_MAP holds one bit per subaddress.
module i2c_regslave_wmap #(
    parameter int                     SUB_W    = 8,
    parameter logic [(1<<SUB_W)-1:0]  WIDE_MAP = '0
) (
    input  logic [SUB_W-1:0] sub,
    output logic             wide
);
    // Index the map by subaddress.
    assign wide = WIDE_MAP[sub];
endmodule

// File: rtl/i2c_regslave.sv
// I2C register slave: matches the chip address, latches a one-byte subaddress,
// and moves one or two data bytes per access through a ready-handshaked
// register port, stretching SCL while that port is busy.
// Assumes the bus pads and the register file live outside this block.
module i2c_regslave
    import i2c_regslave_pkg::*;
#(
    parameter logic [6:0]             CHIP_ADDR   = 7'b1000111,
    parameter int                     SUB_W       = 8,
    parameter int                     SYNC_STAGES = 2,
    parameter logic [(1<<SUB_W)-1:0]  WIDE_MAP    =
        {{(1<<(SUB_W-1)){1'b1}}, {(1<<(SUB_W-1)){1'b0}}}
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_i,
    input  logic                sda_i,
    output logic                scl_oe,
    output logic                sda_oe,
    output logic [SUB_W-1:0]    reg_addr,
    output logic [15:0]         reg_wdata,
    output logic                reg_we,
    output logic                reg_re,
    input  logic [15:0]         reg_rdata,
    input  logic                reg_ready
);
    localparam int DATA_W = 2 * BYTE_W;

    logic sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic wide, in_ack, mack;
    logic [CNT_W-1:0]  bitcnt;
    logic [1:0]        nbytes;
    logic [BYTE_W-1:0] shreg, hi_byte, tx, tx_first;
    logic [DATA_W-1:0] rd_buf;
    logic              in_idle;
    phase_t            phase;

    i2c_regslave_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_regslave_wmap #(.SUB_W(SUB_W), .WIDE_MAP(WIDE_MAP)) wmap_i (
        .sub(reg_addr), .wide(wide)
    );

    // First byte sent on a read: the high half for wide registers.
    assign tx_first = wide ? rd_buf[DATA_W-1:BYTE_W] : rd_buf[BYTE_W-1:0];
    assign in_idle  = (phase == PH_IDLE);

    // Protocol sequencer: bit counting, ACK generation, strobes and stretching.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;  bitcnt <= '0;  nbytes <= '0;
            in_ack <= 1'b0;    mack <= 1'b0;  shreg <= '0;
            hi_byte <= '0;     tx <= '0;      rd_buf <= '0;
            reg_addr <= '0;    reg_wdata <= '0;
            reg_we <= 1'b0;    reg_re <= 1'b0;
            scl_oe <= 1'b0;    sda_oe <= 1'b0;
        end else if (start_det) begin
            phase <= PH_ADDR;  bitcnt <= '0;  in_ack <= 1'b0;  sda_oe <= 1'b0;
        end else if (stop_det) begin
            phase <= PH_IDLE;  in_ack <= 1'b0;  sda_oe <= 1'b0;
        end else if (reg_we || reg_re) begin
            if (reg_ready) begin
                reg_we <= 1'b0;
                reg_re <= 1'b0;
                scl_oe <= 1'b0;
                if (reg_re) rd_buf <= reg_rdata;
            end
        end else begin
            case (phase)
                PH_ADDR, PH_SUB, PH_WDATA: begin
                    if (scl_rise && !in_ack && bitcnt != CNT_W'(8)) begin
                        shreg  <= {shreg[BYTE_W-2:0], sda_s};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (scl_fall && !in_ack && bitcnt == CNT_W'(8)) begin
                        in_ack <= 1'b1;
                        if (phase == PH_ADDR) begin
                            if (shreg[7:1] == CHIP_ADDR) begin
                                sda_oe <= 1'b1;
                                mack   <= shreg[0];
                                if (shreg[0]) begin
                                    reg_re <= 1'b1;
                                    scl_oe <= 1'b1;
                                end
                            end else begin
                                phase  <= PH_IDLE;
                                in_ack <= 1'b0;
                            end
                        end else if (phase == PH_SUB) begin
                            reg_addr <= shreg;
                            nbytes   <= '0;
                            sda_oe   <= 1'b1;
                        end else if (nbytes == 2'd0 && wide) begin
                            hi_byte <= shreg;
                            nbytes  <= 2'd1;
                            sda_oe  <= 1'b1;
                        end else if (nbytes != 2'd2) begin
                            reg_wdata <= nbytes == 2'd1 ? {hi_byte, shreg}
                                                        : {{BYTE_W{1'b0}}, shreg};
                            reg_we    <= 1'b1;
                            scl_oe    <= 1'b1;
                            nbytes    <= 2'd2;
                            sda_oe    <= 1'b1;
                        end
                    end else if (scl_fall && in_ack) begin
                        in_ack <= 1'b0;
                        bitcnt <= '0;
                        sda_oe <= 1'b0;
                        if (phase == PH_SUB) begin
                            phase <= PH_WDATA;
                        end else if (phase == PH_ADDR) begin
                            if (mack) begin
                                phase  <= PH_RDATA;
                                nbytes <= '0;
                                tx     <= tx_first;
                                sda_oe <= ~tx_first[BYTE_W-1];
                            end else begin
                                phase  <= PH_SUB;
                            end
                        end
                    end
                end
                PH_RDATA: begin
                    if (scl_rise && in_ack) begin
                        mack <= ~sda_s;
                    end else if (scl_fall && !in_ack) begin
                        if (bitcnt == CNT_W'(7)) begin
                            sda_oe <= 1'b0;
                            in_ack <= 1'b1;
                        end else begin
                            tx     <= {tx[BYTE_W-2:0], 1'b0};
                            sda_oe <= ~tx[BYTE_W-2];
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end else if (scl_fall && in_ack) begin
                        in_ack <= 1'b0;
                        bitcnt <= '0;
                        if (mack && wide && nbytes == 2'd0) begin
                            nbytes <= 2'd1;
                            tx     <= rd_buf[BYTE_W-1:0];
                            sda_oe <= ~rd_buf[BYTE_W-1];
                        end else begin
                            phase  <= PH_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/i2c_regslave_chk.sv
// Checker: cycle-level properties of the register handshake, clock
// stretching and SDA timing; bound into every i2c_regslave instance.
module i2c_regslave_chk #(
    parameter int SUB_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_we,
    input logic             reg_re,
    input logic             reg_ready,
    input logic [SUB_W-1:0] reg_addr,
    input logic [15:0]      reg_wdata,
    input logic             scl_oe,
    input logic             sda_oe,
    input logic             scl_fall,
    input logic             stop_det,
    input logic             in_idle
);
    // R11
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_re));
    // R11
    we_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !reg_ready) |=> reg_we && $stable(reg_addr) && $stable(reg_wdata));
    // R11
    re_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_re && !reg_ready) |=> reg_re && $stable(reg_addr));
    // R11
    strobe_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_we || reg_re) && reg_ready) |=> !reg_we && !reg_re);
    // R12
    stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we || reg_re) |-> scl_oe);
    // R12
    stretch_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_we || reg_re) && reg_ready) |=> !scl_oe);
    // R13
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe && !scl_oe);
    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_idle |-> !sda_oe && !reg_we && !reg_re);
    // R14
    sda_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> $past(scl_fall));
endmodule

bind i2c_regslave i2c_regslave_chk #(.SUB_W(SUB_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
    .reg_ready(reg_ready), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .scl_fall(scl_fall),
    .stop_det(stop_det), .in_idle(in_idle)
);

// File: tb/i2c_regslave_tb_top.sv
`timescale 1ns/1ps
// Bench: bit-level I2C master, register-file model with variable ready delay,
// and a scoreboard queue of expected register commits.
module i2c_regslave_tb_top;
    localparam int         Q    = 8;
    localparam logic [6:0] ME   = 7'b1000111;
    localparam logic [6:0] NOTME = 7'b1000101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic scl_oe, sda_oe, reg_we, reg_re, reg_ready;
    logic [7:0]  reg_addr;
    logic [15:0] reg_wdata, reg_rdata;
    logic [15:0] mem [256];
    logic scl_bus, sda_bus, scl_prev, sda_oe_prev;
    int checks = 0, errors = 0;
    int rdy_delay = 0, wait_cnt = 0, stretch_cnt = 0, sda_bad = 0;
    logic flip_pend = 1'b0;
    logic [7:0] flip_addr;
    logic [23:0] exp_q [$];

    always #10 clk = ~clk;

    assign scl_bus   = scl_m & ~scl_oe;
    assign sda_bus   = sda_m & ~sda_oe;
    assign reg_rdata = mem[reg_addr];
    assign reg_ready = (reg_we || reg_re) && (wait_cnt > rdy_delay);

    i2c_regslave dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re),
        .reg_rdata(reg_rdata), .reg_ready(reg_ready)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Register-file model and scoreboard monitor.
    always @(negedge clk) begin
        if (flip_pend) begin
            mem[flip_addr] = ~mem[flip_addr];
            flip_pend = 1'b0;
        end
        if (scl_oe) stretch_cnt++;
        if (scl_prev && scl_bus && (sda_oe !== sda_oe_prev)) sda_bad++;
        scl_prev = scl_bus;
        sda_oe_prev = sda_oe;
        if (reg_we || reg_re) wait_cnt++;
        else                  wait_cnt = 0;
        if ((reg_we || reg_re) && (wait_cnt > rdy_delay)) begin
            if (reg_we) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R11 unexpected write", {8'h0, reg_addr, reg_wdata}, 32'h0);
                end else begin
                    logic [23:0] e;
                    e = exp_q.pop_front();
                    chk({reg_addr, reg_wdata} == e, "R4/R6/R7 commit", {8'h0, reg_addr, reg_wdata}, {8'h0, e});
                end
                mem[reg_addr] = reg_wdata;
            end
            if (reg_re) begin
                flip_pend = 1'b1;
                flip_addr = reg_addr;
            end
        end
    end

    task automatic dly(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic scl_up;
        scl_m = 1'b1;
        do @(negedge clk); while (scl_bus !== 1'b1);
    endtask

    task automatic m_start;
        sda_m = 1'b1; dly(Q); scl_up(); dly(Q);
        sda_m = 1'b0; dly(Q); scl_m = 1'b0; dly(Q);
    endtask

    task automatic m_stop;
        sda_m = 1'b0; dly(Q); scl_up(); dly(Q); sda_m = 1'b1; dly(Q);
    endtask

    task automatic m_wbit(input logic b);
        sda_m = b; dly(Q); scl_up(); dly(Q); scl_m = 1'b0; dly(Q);
    endtask

    task automatic m_rbit(output logic b);
        sda_m = 1'b1; dly(Q); scl_up(); dly(Q/2); b = sda_bus;
        dly(Q/2); scl_m = 1'b0; dly(Q);
    endtask

    task automatic tx_byte(input logic [7:0] b, input logic exp_ack, input string req);
        logic r;
        for (int i = 7; i >= 0; i--) m_wbit(b[i]);
        m_rbit(r);
        chk(r == !exp_ack, req, {31'h0, !r}, {31'h0, exp_ack});
    endtask

    task automatic rx_byte(input logic send_ack, input logic [7:0] exp, input string req);
        logic [7:0] got;
        logic r;
        for (int i = 7; i >= 0; i--) begin
            m_rbit(r);
            got[i] = r;
        end
        m_wbit(!send_ack);
        chk(got == exp, req, {24'h0, got}, {24'h0, exp});
    endtask

    task automatic wr1(input logic [7:0] sub, input logic [7:0] d, input string req);
        m_start(); tx_byte({ME, 1'b0}, 1'b1, "R2 write address ACK");
        tx_byte(sub, 1'b1, "R4 subaddress ACK");
        tx_byte(d, 1'b1, req); m_stop();
    endtask

    task automatic wr2(input logic [7:0] sub, input logic [7:0] d0, input logic [7:0] d1,
                       input logic ack1, input string req);
        m_start(); tx_byte({ME, 1'b0}, 1'b1, "R2 write address ACK");
        tx_byte(sub, 1'b1, "R4 subaddress ACK");
        tx_byte(d0, 1'b1, req); tx_byte(d1, ack1, req); m_stop();
    endtask

    task automatic rd(input logic [7:0] sub, input logic wide, input logic [15:0] exp, input string req);
        m_start(); tx_byte({ME, 1'b0}, 1'b1, "R2 write address ACK");
        tx_byte(sub, 1'b1, "R4 subaddress ACK");
        m_start(); tx_byte({ME, 1'b1}, 1'b1, "R2 read address ACK");
        if (wide) begin
            rx_byte(1'b1, exp[15:8], req);
            rx_byte(1'b0, exp[7:0], req);
        end else begin
            rx_byte(1'b0, exp[7:0], req);
        end
        m_stop();
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = {i[7:0] ^ 8'h5A, i[7:0]};
        scl_prev = 1'b1; sda_oe_prev = 1'b0;
        dly(4);
        chk({sda_oe, scl_oe, reg_we, reg_re} == 4'b0, "R1 outputs in reset",
            {28'h0, sda_oe, scl_oe, reg_we, reg_re}, 32'h0);
        rst_n = 1'b1;
        dly(4);
        chk({sda_oe, scl_oe, reg_we, reg_re} == 4'b0, "R1 outputs after reset",
            {28'h0, sda_oe, scl_oe, reg_we, reg_re}, 32'h0);

        // R6: 8-bit write.
        exp_q.push_back({8'h12, 16'h003C});
        wr1(8'h12, 8'h3C, "R6 8-bit data ACK");
        // R7 and R5: 16-bit write at the bottom of the wide range, slow port.
        rdy_delay = 3;
        exp_q.push_back({8'h80, 16'hC3D4});
        wr2(8'h80, 8'hC3, 8'hD4, 1'b1, "R7 16-bit data ACK");
        // R5 and R8: top of the narrow range takes one byte; the second is NAKed.
        rdy_delay = 0;
        exp_q.push_back({8'h7F, 16'h00AB});
        wr2(8'h7F, 8'hAB, 8'hCD, 1'b0, "R8 R5 extra byte NAK");
        // R3: the other instance's address gets NAK and no byte is acknowledged.
        m_start(); tx_byte({NOTME, 1'b0}, 1'b0, "R3 foreign address NAK");
        tx_byte(8'h30, 1'b0, "R3 ignored byte"); tx_byte(8'h99, 1'b0, "R3 ignored byte");
        m_stop();
        // R7 and R13: STOP after the high byte commits nothing.
        m_start(); tx_byte({ME, 1'b0}, 1'b1, "R2 write address ACK");
        tx_byte(8'h90, 1'b1, "R4 subaddress ACK");
        tx_byte(8'h77, 1'b1, "R7 high byte ACK"); m_stop();
        // R9: 8-bit read returns the low byte.
        rd(8'h12, 1'b0, 16'h003C, "R9 8-bit read");
        // R7: 0x90 still holds its initial value.
        rd(8'h90, 1'b1, 16'hCA90, "R7 no partial commit");
        // R10 and R12: 16-bit read snapshot with a long stretch.
        rdy_delay = 40; stretch_cnt = 0;
        rd(8'h80, 1'b1, 16'hC3D4, "R10 16-bit read snapshot");
        chk(stretch_cnt > 40, "R12 read stretch cycles", stretch_cnt, 41);
        // R12: slow 16-bit write.
        stretch_cnt = 0;
        exp_q.push_back({8'hA0, 16'h1234});
        wr2(8'hA0, 8'h12, 8'h34, 1'b1, "R12 stretched write ACK");
        chk(stretch_cnt > 40, "R12 write stretch cycles", stretch_cnt, 41);
        rdy_delay = 0;
        // R13: a START in the middle of a byte aborts it.
        m_start(); tx_byte({ME, 1'b0}, 1'b1, "R2 write address ACK");
        tx_byte(8'h40, 1'b1, "R4 subaddress ACK");
        for (int i = 0; i < 4; i++) m_wbit(1'b1);
        exp_q.push_back({8'h41, 16'h0055});
        m_start(); tx_byte({ME, 1'b0}, 1'b1, "R13 address after restart");
        tx_byte(8'h41, 1'b1, "R13 subaddress after restart");
        tx_byte(8'h55, 1'b1, "R13 data after restart"); m_stop();

        dly(20);
        chk(exp_q.size() == 0, "R11 all commits seen", exp_q.size(), 0);
        chk({sda_oe, scl_oe} == 2'b00, "R13 lines released at end", {30'h0, sda_oe, scl_oe}, 0);
        chk(sda_bad == 0, "R14 SDA steady while SCL high", sda_bad, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule